// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the slave side of a network controller's register interface. It sits behind a 32-byte I/O window. The host never addresses a register directly. It first loads a register index into a pointer port, then moves data through one of two data ports. One data port reaches the control/status bank and the other reaches the configuration bank, and both banks share the same pointer. Two byte-wide address layouts exist. One is for 16-bit word accesses and one is for 32-bit dword accesses. A small state machine tracks which layout is active.

Reading the reset port performs a soft reset of the controller state. The six bytes of the station address can be read as single bytes at the bottom of the window. The control bank also exposes a fixed 32-bit chip identifier, and the configuration bank holds the descriptor-style selector that the rest of the controller decodes.

Access-mode state machine:
- States: `MODE_WORD` (the reset state) and `MODE_DWORD`.
- Transition `T_WIDEN`: `MODE_WORD` → `MODE_DWORD` on a 32-bit write to offset 0x10.
- `MODE_DWORD` has no exit except the hardware reset `rst_n`.

Top module: `iap_port`

## Requirements
- R1: After hardware reset the port is in word mode, `dword_mode` and `desc32` are low, the pointer reads 0, control register 0 reads 0x0004 and every configuration register reads 0.
- R2: In word mode, 16-bit accesses (size code 1) decode as follows: control data at 0x10, pointer at 0x12, reset port at 0x14, configuration data at 0x16.
- R3: In dword mode, 32-bit accesses (size code 2) use the same ports at 0x10, 0x14, 0x18 and 0x1C. A 32-bit write to 0x10 in word mode moves the port to dword mode and its data is discarded. Dword mode is left only by hardware reset.
- R4: An access whose size does not match the current mode, other than the widening write of R3, is ignored. A write changes nothing, and a read returns 0.
- R5: The pointer keeps 16 bits and reads back exactly as written; the upper 16 bits of a dword write are dropped. The register index is the pointer's low 7 bits.
- R6: Every read returns its value in bits 15:0, with bits 31:16 zero.
- R7: A read of the reset port returns 0. It restores the control bank (register 0 to 0x0004, the rest to 0) and clears the pointer. It leaves the configuration bank and the access mode unchanged.
- R8: Byte reads (size code 0) at offsets 0 to 5 return station-address byte N (bits 8N+7:8N of `station_addr`) in bits 7:0. Byte reads at any other offset return 0.
- R9: `desc32` is high exactly when configuration register 20 holds 2 or 3.
- R10: Control register 88 reads {PART_CODE[3:0], 12'h003} and register 89 reads {4'h0, PART_CODE[15:4]}. Both ignore writes.
- R11: Control indices at or above CSR_DEPTH (other than 88 and 89) and configuration indices at or above CFG_DEPTH read 0. Writes to them have no effect.
- R12: `bus_rvalid` is high in the cycle after each read request and low otherwise. `bus_rdata` carries the value sampled at the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | 5 | Byte offset within the I/O window |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| bus_wr | input | 1 | Write request (ignored while bus_rd is high) |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| station_addr | input | 48 | Stored station address, byte 0 in bits 7:0 |
| dword_mode | output | 1 | High while the dword layout is active |
| desc32 | output | 1 | 32-bit descriptor style selected |

## Verification
The bench builds the block with its default parameters. With CSR_DEPTH at 8 and CFG_DEPTH at 32, indices 50 and 40 are unimplemented, while the style selector at index 20 is a real register. This brings the R11 dead-index paths and the R9 selector within reach together. PART_CODE 0x2627 gives two identifier halves, 0x7003 and 0x0262, that differ from each other and from every value the bench writes. The same read sequences run in word mode and in dword mode, so each offset is tested against both layouts. The soft reset is checked in each mode as well.

// File: rtl/iap_pkg.sv
package iap_pkg;
    localparam int ADDR_W = 5;
    localparam int BUS_W  = 32;
    localparam int REG_W  = 16;
    localparam int IDX_W  = 7;
    localparam int STATION_BYTES = 6;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        PORT_NONE,
        PORT_CSR_DATA,
        PORT_POINTER,
        PORT_SOFT_RST,
        PORT_CFG_DATA,
        PORT_STATION
    } port_e;

    typedef enum logic {
        MODE_WORD,
        MODE_DWORD
    } mode_e;

    localparam logic [ADDR_W-1:0] OFS_CSR_DATA = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_W_PTR    = 5'h12;
    localparam logic [ADDR_W-1:0] OFS_W_RST    = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_W_CFG    = 5'h16;
    localparam logic [ADDR_W-1:0] OFS_D_PTR    = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_D_RST    = 5'h18;
    localparam logic [ADDR_W-1:0] OFS_D_CFG    = 5'h1C;

    localparam logic [REG_W-1:0] CSR0_RESET = 16'h0004;
    localparam int ID_LO_IDX = 88;
    localparam int ID_HI_IDX = 89;
endpackage

// File: rtl/iap_mode_fsm.sv
module iap_mode_fsm
    import iap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output logic              dword_mode
);
    mode_e state_q, state_d;
    logic  widen;

    assign widen = wr_acc && (size == SZ_DWORD) && (addr == OFS_CSR_DATA);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_WORD:  if (widen) state_d = MODE_DWORD;   // T_WIDEN
            MODE_DWORD: state_d = MODE_DWORD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_WORD;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MODE_WORD:  dword_mode = 1'b0;
            MODE_DWORD: dword_mode = 1'b1;
        endcase
    end
endmodule

// File: rtl/iap_decode.sv
module iap_decode
    import iap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              dword_mode,
    output port_e             sel,
    output logic [2:0]        st_idx
);
    assign st_idx = addr[2:0];

    always_comb begin
        sel = PORT_NONE;
        if (size == SZ_BYTE) begin
            if (int'(addr) < STATION_BYTES) sel = PORT_STATION;
        end else if (!dword_mode && size == SZ_WORD) begin
            unique case (addr)
                OFS_CSR_DATA: sel = PORT_CSR_DATA;
                OFS_W_PTR:    sel = PORT_POINTER;
                OFS_W_RST:    sel = PORT_SOFT_RST;
                OFS_W_CFG:    sel = PORT_CFG_DATA;
                default:      sel = PORT_NONE;
            endcase
        end else if (dword_mode && size == SZ_DWORD) begin
            unique case (addr)
                OFS_CSR_DATA: sel = PORT_CSR_DATA;
                OFS_D_PTR:    sel = PORT_POINTER;
                OFS_D_RST:    sel = PORT_SOFT_RST;
                OFS_D_CFG:    sel = PORT_CFG_DATA;
                default:      sel = PORT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/iap_regbank.sv
module iap_regbank
    import iap_pkg::*;
#(
    parameter int              DEPTH     = 8,
    parameter int              DW        = REG_W,
    parameter logic [DW-1:0]   RST0      = '0,
    parameter bit              CLEARABLE = 1'b1,
    parameter int              TAP_IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [DW-1:0]    rdata,
    output logic [DW-1:0]    tap
);
    localparam int TAP_SAFE = (TAP_IDX < DEPTH) ? TAP_IDX : 0;

    logic [DW-1:0] bank [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam logic [DW-1:0] INIT = (g == 0) ? RST0 : '0;
        logic [DW-1:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    ent_q <= INIT;
            else if (clear && CLEARABLE)   ent_q <= INIT;
            else if (we && widx == IDX_W'(g)) ent_q <= wdata;
        end
        assign bank[g] = ent_q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++)
            if (ridx == IDX_W'(i)) rdata = bank[i];
    end

    assign tap = bank[TAP_SAFE];
endmodule

// File: rtl/iap_port.sv
module iap_port
    import iap_pkg::*;
#(
    parameter int          CSR_DEPTH = 8,
    parameter int          CFG_DEPTH = 32,
    parameter int          STYLE_IDX = 20,
    parameter logic [15:0] PART_CODE = 16'h2627
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [1:0]                 bus_size,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [BUS_W-1:0]           bus_wdata,
    output logic [BUS_W-1:0]           bus_rdata,
    output logic                       bus_rvalid,
    input  logic [8*STATION_BYTES-1:0] station_addr,
    output logic                       dword_mode,
    output logic                       desc32
);
    localparam logic [REG_W-1:0] ID_LO = {PART_CODE[3:0], 12'h003};
    localparam logic [REG_W-1:0] ID_HI = {4'h0, PART_CODE[15:4]};

    logic             rd_acc, wr_acc, soft_rst;
    port_e            sel;
    logic [2:0]       st_idx;
    logic [REG_W-1:0] ptr_q;
    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] csr_bank_rd, csr_val, cfg_rd, cfg_tap, csr_tap_unused;
    logic [7:0]       st_byte;
    logic [BUS_W-1:0] rd_mux;
    logic             unused_wdata_hi;

    assign rd_acc   = bus_rd;
    assign wr_acc   = bus_wr && !bus_rd;
    assign idx      = ptr_q[IDX_W-1:0];
    assign soft_rst = rd_acc && (sel == PORT_SOFT_RST);
    assign unused_wdata_hi = ^{bus_wdata[BUS_W-1:REG_W], csr_tap_unused};

    iap_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_acc     (wr_acc),
        .size       (bus_size),
        .addr       (bus_addr),
        .dword_mode (dword_mode)
    );

    iap_decode u_dec (
        .addr       (bus_addr),
        .size       (bus_size),
        .dword_mode (dword_mode),
        .sel        (sel),
        .st_idx     (st_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              ptr_q <= '0;
        else if (soft_rst)                       ptr_q <= '0;
        else if (wr_acc && sel == PORT_POINTER)  ptr_q <= bus_wdata[REG_W-1:0];
    end

    iap_regbank #(
        .DEPTH(CSR_DEPTH), .DW(REG_W), .RST0(CSR0_RESET), .CLEARABLE(1'b1), .TAP_IDX(0)
    ) u_csr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (soft_rst),
        .we    (wr_acc && sel == PORT_CSR_DATA),
        .widx  (idx),
        .wdata (bus_wdata[REG_W-1:0]),
        .ridx  (idx),
        .rdata (csr_bank_rd),
        .tap   (csr_tap_unused)
    );

    iap_regbank #(
        .DEPTH(CFG_DEPTH), .DW(REG_W), .RST0('0), .CLEARABLE(1'b0), .TAP_IDX(STYLE_IDX)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (soft_rst),
        .we    (wr_acc && sel == PORT_CFG_DATA),
        .widx  (idx),
        .wdata (bus_wdata[REG_W-1:0]),
        .ridx  (idx),
        .rdata (cfg_rd),
        .tap   (cfg_tap)
    );

    assign desc32 = (cfg_tap == 16'h0002) || (cfg_tap == 16'h0003);

    always_comb begin
        if (idx == IDX_W'(ID_LO_IDX))      csr_val = ID_LO;
        else if (idx == IDX_W'(ID_HI_IDX)) csr_val = ID_HI;
        else                               csr_val = csr_bank_rd;
    end

    always_comb begin
        st_byte = '0;
        for (int i = 0; i < STATION_BYTES; i++)
            if (st_idx == 3'(i)) st_byte = station_addr[i*8 +: 8];
    end

    always_comb begin
        unique case (sel)
            PORT_CSR_DATA: rd_mux = {{(BUS_W-REG_W){1'b0}}, csr_val};
            PORT_POINTER:  rd_mux = {{(BUS_W-REG_W){1'b0}}, ptr_q};
            PORT_CFG_DATA: rd_mux = {{(BUS_W-REG_W){1'b0}}, cfg_rd};
            PORT_STATION:  rd_mux = {{(BUS_W-8){1'b0}}, st_byte};
            default:       rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rdata  <= rd_acc ? rd_mux : '0;
            bus_rvalid <= rd_acc;
        end
    end
endmodule

// File: rtl/iap_port_chk.sv
module iap_port_chk
    import iap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              bus_rvalid,
    input logic              dword_mode,
    input logic              desc32
);
    logic rst_port_rd;
    assign rst_port_rd = bus_rd &&
        ((!dword_mode && bus_size == 2'd1 && bus_addr == 5'h14) ||
         ( dword_mode && bus_size == 2'd2 && bus_addr == 5'h18));

    assert_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    assert_rvalid_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> bus_rdata[31:16] == 16'h0);
    assert_mode_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dword_mode |=> dword_mode);
    assert_widen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dword_mode && bus_wr && !bus_rd && bus_size == 2'd2 && bus_addr == 5'h10)
        |=> dword_mode);
    assert_mismatch_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ((!dword_mode && bus_size == 2'd2) || (dword_mode && bus_size == 2'd1)))
        |=> bus_rdata == '0);
    assert_reset_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_port_rd |=> bus_rdata == '0);
    assert_byte_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_size == 2'd0 && bus_addr > 5'd5) |=> bus_rdata == '0);
    assert_desc_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(desc32));
endmodule

bind iap_port iap_port_chk u_chk (.*);

// File: tb/sim_iap_port.sv
`timescale 1ns/1ps
module sim_iap_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [47:0] station_addr = 48'h0A1B2C3D4E5F;
    logic        dword_mode;
    logic        desc32;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    iap_port u0 (.*);

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [4:0]  ad;
        logic [31:0] dat;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd1, 5'h10, 32'h0,    32'h0004, 4'd1},  // R1 CSR0 reset value
        '{1'b0, 2'd1, 5'h12, 32'h0,    32'h0000, 4'd1},  // R1 pointer reset
        '{1'b1, 2'd1, 5'h12, 32'd88,   32'h0,    4'd5},
        '{1'b0, 2'd1, 5'h12, 32'h0,    32'd88,   4'd5},  // R5 pointer readback
        '{1'b0, 2'd1, 5'h10, 32'h0,    32'h7003, 4'd10}, // R10 id low
        '{1'b1, 2'd1, 5'h12, 32'd89,   32'h0,    4'd10},
        '{1'b0, 2'd1, 5'h10, 32'h0,    32'h0262, 4'd10}, // R10 id high
        '{1'b1, 2'd1, 5'h10, 32'hFFFF, 32'h0,    4'd10},
        '{1'b0, 2'd1, 5'h10, 32'h0,    32'h0262, 4'd10}, // R10 write ignored
        '{1'b1, 2'd1, 5'h12, 32'd3,    32'h0,    4'd2},
        '{1'b1, 2'd1, 5'h10, 32'h5A5A, 32'h0,    4'd2},
        '{1'b0, 2'd1, 5'h10, 32'h0,    32'h5A5A, 4'd2},  // R2 control data port
        '{1'b1, 2'd1, 5'h12, 32'd20,   32'h0,    4'd2},
        '{1'b1, 2'd1, 5'h16, 32'h0002, 32'h0,    4'd2},
        '{1'b0, 2'd1, 5'h16, 32'h0,    32'h0002, 4'd2},  // R2 config data port
        '{1'b1, 2'd1, 5'h12, 32'd50,   32'h0,    4'd11},
        '{1'b1, 2'd1, 5'h10, 32'h1234, 32'h0,    4'd11},
        '{1'b0, 2'd1, 5'h10, 32'h0,    32'h0,    4'd11}, // R11 dead control index
        '{1'b1, 2'd1, 5'h12, 32'd40,   32'h0,    4'd11},
        '{1'b1, 2'd1, 5'h16, 32'hBEEF, 32'h0,    4'd11},
        '{1'b0, 2'd1, 5'h16, 32'h0,    32'h0,    4'd11}, // R11 dead config index
        '{1'b1, 2'd1, 5'h12, 32'h0085, 32'h0,    4'd5},
        '{1'b0, 2'd1, 5'h12, 32'h0,    32'h0085, 4'd5},  // R5 full 16 bits kept
        '{1'b1, 2'd1, 5'h10, 32'h0101, 32'h0,    4'd5},  // lands in index 5
        '{1'b1, 2'd1, 5'h12, 32'd5,    32'h0,    4'd5},
        '{1'b0, 2'd1, 5'h10, 32'h0,    32'h0101, 4'd5},  // R5 low 7 bits index
        '{1'b0, 2'd0, 5'h00, 32'h0,    32'h5F,   4'd8},  // R8 station byte 0
        '{1'b0, 2'd0, 5'h03, 32'h0,    32'h2C,   4'd8},  // R8 station byte 3
        '{1'b0, 2'd0, 5'h05, 32'h0,    32'h0A,   4'd8},  // R8 station byte 5
        '{1'b0, 2'd0, 5'h06, 32'h0,    32'h0,    4'd8},  // R8 outside range
        '{1'b1, 2'd2, 5'h14, 32'h7,    32'h0,    4'd4},  // dword write in word mode
        '{1'b0, 2'd1, 5'h12, 32'h0,    32'd5,    4'd4},  // R4 pointer untouched
        '{1'b0, 2'd2, 5'h10, 32'h0,    32'h0,    4'd4},  // R4 mismatched read
        '{1'b1, 2'd1, 5'h12, 32'd20,   32'h0,    4'd9},
        '{1'b0, 2'd1, 5'h16, 32'h0,    32'h0002, 4'd9}   // R9 selector readback
    };

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp,
                         input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] sz, input logic [4:0] ad, input logic [31:0] d);
        @(negedge clk);
        bus_size = sz; bus_addr = ad; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input int req, input logic [1:0] sz, input logic [4:0] ad,
                           input logic [31:0] exp, input string what);
        @(negedge clk);
        bus_size = sz; bus_addr = ad; bus_rd = 1'b1; bus_wr = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0;
        check(12, 32'(bus_rvalid), 32'd1, "rvalid after read");      // R12
        check(req, bus_rdata, exp, what);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(1, 32'(dword_mode), 32'd0, "word mode after reset");    // R1
        check(1, 32'(desc32), 32'd0, "desc32 low after reset");       // R1

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].wr) do_write(TBL[i].sz, TBL[i].ad, TBL[i].dat);
            else do_read(int'(TBL[i].req), TBL[i].sz, TBL[i].ad, TBL[i].exp, "table vector");
        end

        // R9 selector decode, pointer is at 20
        check(9, 32'(desc32), 32'd1, "desc32 with 2");
        do_write(2'd1, 5'h16, 32'h0);
        check(9, 32'(desc32), 32'd0, "desc32 with 0");
        do_write(2'd1, 5'h16, 32'h3);
        check(9, 32'(desc32), 32'd1, "desc32 with 3");
        do_write(2'd1, 5'h16, 32'h2);
        check(12, 32'(bus_rvalid), 32'd0, "no rvalid after write");   // R12

        // R7 soft reset in word mode
        do_write(2'd1, 5'h12, 32'd3);
        do_read(7, 2'd1, 5'h14, 32'h0, "reset port reads zero");
        do_read(7, 2'd1, 5'h12, 32'h0, "pointer cleared");
        do_read(7, 2'd1, 5'h10, 32'h0004, "CSR0 restored");
        do_write(2'd1, 5'h12, 32'd3);
        do_read(7, 2'd1, 5'h10, 32'h0, "CSR3 cleared");
        do_write(2'd1, 5'h12, 32'd20);
        do_read(7, 2'd1, 5'h16, 32'h0002, "config bank kept");
        check(7, 32'(dword_mode), 32'd0, "mode kept word");

        // R3 widen to dword mode
        do_write(2'd2, 5'h10, 32'hDEAD);
        check(3, 32'(dword_mode), 32'd1, "dword mode entered");
        do_write(2'd2, 5'h14, 32'h0);
        do_read(3, 2'd2, 5'h10, 32'h0004, "widening write discarded");
        do_write(2'd2, 5'h14, 32'hABCD0058);
        do_read(5, 2'd2, 5'h14, 32'h0058, "pointer upper half dropped");
        do_read(6, 2'd2, 5'h10, 32'h7003, "dword read in low half");
        do_write(2'd2, 5'h14, 32'd20);
        do_read(3, 2'd2, 5'h1C, 32'h0002, "config port at 0x1C");
        do_write(2'd1, 5'h12, 32'd7);
        do_read(4, 2'd2, 5'h14, 32'd20, "word write ignored in dword mode");
        do_read(4, 2'd1, 5'h10, 32'h0, "word read ignored in dword mode");
        do_write(2'd2, 5'h14, 32'd1);
        do_write(2'd2, 5'h10, 32'h0000CAFE);
        do_read(3, 2'd2, 5'h10, 32'h0000CAFE, "dword control write");
        check(3, 32'(dword_mode), 32'd1, "dword mode sticky");

        // R7 soft reset in dword mode
        do_read(7, 2'd2, 5'h18, 32'h0, "reset port at 0x18");
        check(7, 32'(dword_mode), 32'd1, "mode kept dword");
        do_read(7, 2'd2, 5'h14, 32'h0, "pointer cleared dword");
        do_read(7, 2'd2, 5'h10, 32'h0004, "CSR0 restored dword");
        do_read(8, 2'd0, 5'h01, 32'h4E, "station byte 1 in dword mode");

        // R1 hardware reset
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(1, 32'(dword_mode), 32'd0, "word mode after hw reset");
        check(1, 32'(desc32), 32'd0, "desc32 after hw reset");
        do_read(1, 2'd1, 5'h10, 32'h0004, "CSR0 after hw reset");
        do_write(2'd1, 5'h12, 32'd20);
        do_read(1, 2'd1, 5'h16, 32'h0, "config cleared by hw reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule